// File: doc/BRIEF.md
# Masked-Address GPIO Data Port

This block is the data path of an eight-pin general-purpose I/O port. The data register is not reached at a single address. It is spread over a window of 256 word addresses, and byte-address bits [9:2] of each access act as a per-pin mask. A write changes only the pins whose mask bit is set. Software can therefore set, clear or rewrite any subset of pins in one bus cycle, with no read-modify-write and no race against other agents that share the port. A read returns zero on the masked-out bit positions, so one access both selects the pins and isolates them.

The port holds an output latch that drives the pin output values. It registers a per-pin direction input to drive the output enables. The pin inputs go through a two-flop synchronizer before they can be read. On a read, each masked-in bit returns the output latch if that pin is an output, or the synchronized input if it is an input. The bus interface is a plain valid/write/address/data request. A write completes at the clock edge that accepts it. Read data arrives one cycle after the request, with a one-cycle valid strobe.

Top module: `masked_gpio_port`

## Requirements
- R1: After synchronous reset, pin_out, pin_oe, rd_valid and rd_data are all zero, and the synchronizer holds zero.
- R2: The pin mask is byte-address bits [9:2]: address bit k+2 selects pin k. Address bits [1:0] have no effect on any access.
- R3: On a clock edge where req_valid and req_write are both 1, every pin whose mask bit is 1 loads the matching req_wdata bit. The new value appears on pin_out right after that edge.
- R4: On the same write, pins whose mask bit is 0 keep their pin_out value, whatever their req_wdata bits are.
- R5: A read (req_valid 1, req_write 0) accepted at an edge raises rd_valid for exactly the next cycle, with the result on rd_data. In every other cycle, rd_valid and rd_data are 0.
- R6: Read bits whose mask bit is 0 return 0.
- R7: A masked-in read bit of a pin with pin_dir = 1 (output) returns that pin's output latch value from before the read edge.
- R8: A masked-in read bit of a pin with pin_dir = 0 (input) returns pin_in as sampled two clock edges before the read edge, through a two-flop synchronizer.
- R9: pin_oe equals pin_dir delayed by one clock cycle.
- R10: An all-ones mask (address 0x3FC) reads and writes all eight pins at once.
- R11: Cycles with req_valid 0, and write cycles, produce no read return. pin_out does not change in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address; bits [9:2] are the pin mask |
| req_wdata | input | 8 | Write data, one bit per pin |
| pin_dir | input | 8 | Per-pin direction, 1 = output |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output latch driving the pins |
| pin_oe | output | 8 | Registered output enables |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Masked read data |

## Verification
The bench targets three kinds of mistake. The first is a write that leaks outside the mask: a design that ignores the mask, or takes it from the wrong address bits, would clear pins when a zero data byte is written under a single-bit mask. The second is a read that leaks masked-out bits, or that returns the latch for input pins. The third is the synchronizer latency. A read issued one edge after an input change must still return the old level, and a read two edges later must return the new one. A design with one stage too few or too many gets one of these two wrong. Address bits [1:0] are set on some accesses to show they are ignored, and a reference model is compared on every clock through a long run of mixed traffic.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  // Lowest byte-address bit that carries the pin mask.
  localparam int unsigned MASK_LSB = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g] <= '0;
      end else begin
        if (g == 0) stage_q[g] <= din;
        else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PINS-1:0] wr_mask,
  input  logic [PINS-1:0] wr_data,
  input  logic [PINS-1:0] dir,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      oe_q <= dir;
      if (wr_en) out_q <= (out_q & ~wr_mask) | (wr_data & wr_mask);
    end
  end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [PINS-1:0] rd_mask,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] latch_val,
  input  logic [PINS-1:0] sync_val,
  output logic            rd_valid,
  output logic [PINS-1:0] rd_data
);
  logic [PINS-1:0] level;

  for (genvar p = 0; p < PINS; p++) begin : g_pick
    assign level[p] = dir[p] ? latch_val[p] : sync_val[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? (level & rd_mask) : '0;
    end
  end
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PINS-1:0]   req_wdata,
  input  logic [PINS-1:0]   pin_dir,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              rd_valid,
  output logic [PINS-1:0]   rd_data
);
  localparam int unsigned SHIFT = MASK_LSB;

  acc_kind_e       kind;
  logic [PINS-1:0] acc_mask;
  logic [PINS-1:0] sync_val;

  assign acc_mask = PINS'(req_addr >> SHIFT);

  always_comb begin
    if (!req_valid)     kind = ACC_IDLE;
    else if (req_write) kind = ACC_WRITE;
    else                kind = ACC_READ;
  end

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (sync_val)
  );

  gpio_out_latch #(.PINS(PINS)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (kind == ACC_WRITE),
    .wr_mask (acc_mask),
    .wr_data (req_wdata),
    .dir     (pin_dir),
    .out_q   (pin_out),
    .oe_q    (pin_oe)
  );

  gpio_read_path #(.PINS(PINS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (kind == ACC_READ),
    .rd_mask   (acc_mask),
    .dir       (pin_dir),
    .latch_val (pin_out),
    .sync_val  (sync_val),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/masked_gpio_port_chk.sv
module masked_gpio_port_chk #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [PINS-1:0]   req_wdata,
  input logic [PINS-1:0]   pin_dir,
  input logic [PINS-1:0]   pin_in,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              rd_valid,
  input logic [PINS-1:0]   rd_data
);
  logic [PINS-1:0] m;
  assign m = PINS'(req_addr >> 2);

  assert_write_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> ((pin_out & $past(m)) == ($past(req_wdata) & $past(m))));

  assert_write_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> ((pin_out & ~$past(m)) == ($past(pin_out) & ~$past(m))));

  assert_read_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> (!rd_valid && rd_data == '0));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(pin_out));

  assert_read_zeros_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> ((rd_data & ~$past(m)) == '0));

  assert_read_latch_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=>
      ((rd_data & $past(m & pin_dir)) == ($past(pin_out) & $past(m & pin_dir))));

  assert_oe_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == $past(pin_dir)));

  logic unused_in;
  assign unused_in = ^pin_in;
endmodule

bind masked_gpio_port masked_gpio_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/masked_gpio_port_bench.sv
`timescale 1ns/1ps
module masked_gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [9:0] req_addr  = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] pin_dir   = '0;
  logic [7:0] pin_in    = '0;
  logic [7:0] pin_out, pin_oe, rd_data;
  logic       rd_valid;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  masked_gpio_port u_masked_gpio_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pin_dir(pin_dir),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Behavioural reference model.
  int          m_out, m_oe, m_rdv, m_rdd;
  int          hist[$];
  bit          model_on = 0;

  always @(posedge clk) begin
    int msk, seen, lvl;
    if (rst) begin
      m_out = 0; m_oe = 0; m_rdv = 0; m_rdd = 0;
      hist.delete();
    end else begin
      msk  = (int'(req_addr) / 4) % 256;
      seen = (hist.size() >= 2) ? hist[hist.size()-2] : 0;
      lvl  = (int'(pin_dir) & m_out) | (~int'(pin_dir) & seen & 255);
      if (req_valid && !req_write) begin
        m_rdv = 1; m_rdd = lvl & msk;
      end else begin
        m_rdv = 0; m_rdd = 0;
      end
      if (req_valid && req_write)
        m_out = (m_out & ~msk & 255) | (int'(req_wdata) & msk);
      m_oe = int'(pin_dir);
      hist.push_back(int'(pin_in));
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R3/R4 pin_out", int'(pin_out), m_out);
      chk("R9 pin_oe", int'(pin_oe), m_oe);
      chk("R5 rd_valid", int'(rd_valid), m_rdv);
      chk("R6/R7/R8 rd_data", int'(rd_data), m_rdd);
    end
  end

  task automatic drive(bit v, bit w, logic [9:0] a, logic [7:0] d);
    @(negedge clk); #1;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    drive(1, 1, a, d);
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic rd_expect(logic [9:0] a, int exp, string tag);
    drive(1, 0, a, 8'h00);
    @(negedge clk);
    chk({tag, " rd_valid"}, int'(rd_valid), 1);
    chk({tag, " rd_data"}, int'(rd_data), exp);
    #1 req_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pin_out", int'(pin_out), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    #1 rst = 0; pin_dir = 8'hFF;
    model_on = 1;

    // R10/R3: full-port write through all-ones mask
    wr(10'h3FC, 8'hA5);
    chk("R10 full write", int'(pin_out), 8'hA5);
    // R4: mask 0x01 with zero data clears only pin 0
    wr(10'h004, 8'h00);
    chk("R4 single pin", int'(pin_out), 8'hA4);
    // R4: mask 0xF0 data 0x0F keeps low nibble
    wr(10'h3C0, 8'h0F);
    chk("R4 upper nibble", int'(pin_out), 8'h04);
    // R2: address bits [1:0] ignored, mask 0x02
    wr(10'h00B, 8'hFF);
    chk("R2 low addr bits", int'(pin_out), 8'h06);
    // R7/R6: partial reads of output pins
    rd_expect(10'h03C, 8'h06, "R7");
    rd_expect(10'h003, 8'h00, "R6");
    rd_expect(10'h3FF, 8'h06, "R10");

    // R8: inputs on upper nibble, synchronizer latency
    drive(0, 0, 10'h0, 8'h0);
    pin_dir = 8'h0F; pin_in = 8'h3C;
    rd_expect(10'h3FC, 8'h06, "R8 early");
    chk("R9 oe", int'(pin_oe), 8'h0F);
    repeat (2) @(negedge clk);
    rd_expect(10'h3FC, 8'h36, "R8 late");
    // R7: latch written for input pins is not read back
    wr(10'h3C0, 8'hF0);
    chk("R3 latch", int'(pin_out), 8'hF6);
    rd_expect(10'h3FC, 8'h36, "R7 inputs");

    // R11: idle with garbage on the bus
    drive(0, 1, 10'h3FC, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 idle pin_out", int'(pin_out), 8'hF6);
    chk("R11 idle rd_valid", int'(rd_valid), 0);
    drive(1, 1, 10'h000, 8'hFF);
    @(negedge clk);
    chk("R11 write no strobe", int'(rd_valid), 0);
    chk("R11 zero mask write", int'(pin_out), 8'hF6);

    // Mixed traffic checked by the model every cycle
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 1), $urandom_range(0, 1),
            10'($urandom), 8'($urandom));
      if (i % 7 == 0) pin_dir = 8'($urandom);
      if (i % 3 == 0) pin_in  = 8'($urandom);
    end
    drive(0, 0, 10'h0, 8'h0);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule